// File: doc/BRIEF.md
# Packed Rounding Multiply-High Unit

This block multiplies two 128-bit operands lane by lane, treating each as eight 16-bit lanes, and returns one 16-bit result per lane. A two-bit mode input, shared by all lanes, picks which part of each product is kept:
- the low half of the product;
- the high half of the signed product;
- the high half of the unsigned product;
- a fixed-point rounded high half.

The rounded mode keeps the top eighteen bits of the signed product, adds one at their least significant bit, and returns the sixteen bits just below the top bit.

A new operand pair is presented with a valid strobe. The packed result is captured in an output register and leaves with its own valid one clock later. While the input strobe is low, the register keeps its last result. The lane count and lane width are parameters. The rounded mode generalises to any lane width W of at least 4 as an arithmetic shift right by W-2, then an increment, then bits W down to 1.

Top module: `pmh_unit`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the cycle after it, out_vld is 0 and out_data is all zero.
- R2: out_vld equals the value in_vld had at the previous rising clock edge.
- R3: With mode 2'b00, each output lane is the low W bits of the lane product.
- R4: With mode 2'b01, each output lane is bits 2W-1..W of the signed product of the two lanes.
- R5: With mode 2'b10, each output lane is bits 2W-1..W of the unsigned product of the two lanes.
- R6: With mode 2'b11, each output lane is bits W..1 of ((signed product >>> (W-2)) + 1).
- R7: In mode 2'b11 with W=16, -32768 times -32768 gives 0x8000, with no saturation.
- R8: Lane i occupies bits W*i+W-1..W*i of op_a, op_b and out_data, and each lane's result depends only on that lane's operands.
- R9: When in_vld is 0, out_data keeps its previous value on the next edge, whatever the operands and the mode are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 00 low, 01 signed high, 10 unsigned high, 11 rounded high |
| op_a | input | LANES*LANE_W | Packed first operand |
| op_b | input | LANES*LANE_W | Packed second operand |
| out_vld | output | 1 | out_data holds a new result |
| out_data | output | LANES*LANE_W | Packed registered result |

## Verification
The bench builds two copies of the block. The first uses eight 4-bit lanes. At that width every one of the 256 operand pairs can be run through every mode, so all rounding carries and sign-boundary cases are covered exhaustively. The second uses the default eight 16-bit lanes. It checks directed corners, including the most-negative-squared case, a single-lane isolation vector and a stream of pseudo-random vectors, against an integer model of the same arithmetic.

// File: rtl/pmh_pkg.sv
package pmh_pkg;

  typedef enum logic [1:0] {
    MUL_LO     = 2'b00,
    MUL_HI_S   = 2'b01,
    MUL_HI_U   = 2'b10,
    MUL_HI_RND = 2'b11
  } mul_mode_e;

endpackage

// File: rtl/pmh_lane.sv
module pmh_lane #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     y
);
  import pmh_pkg::*;

  localparam int PW = 2 * W;
  localparam int RS = W - 2;

  function automatic logic signed [PW-1:0] mul_s(input logic [W-1:0] x, input logic [W-1:0] z);
    logic signed [PW-1:0] xs, zs;
    xs = PW'($signed(x));
    zs = PW'($signed(z));
    return xs * zs;
  endfunction

  function automatic logic [PW-1:0] mul_u(input logic [W-1:0] x, input logic [W-1:0] z);
    logic [PW-1:0] xu, zu;
    xu = {{W{1'b0}}, x};
    zu = {{W{1'b0}}, z};
    return xu * zu;
  endfunction

  function automatic logic [W-1:0] round_hi(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] trimmed;
    logic [PW-1:0]        bumped;
    trimmed = p >>> RS;
    bumped  = trimmed + {{(PW-1){1'b0}}, 1'b1};
    return bumped[W:1];
  endfunction

  // named internal results, visible to the checks below
  logic signed [PW-1:0] prod_s;
  logic [PW-1:0]        prod_u;
  logic [W-1:0]         res_lo;
  logic [W-1:0]         res_hs;
  logic [W-1:0]         res_hu;
  logic [W-1:0]         res_rn;

  assign prod_s = mul_s(a, b);
  assign prod_u = mul_u(a, b);
  assign res_lo = prod_u[W-1:0];
  assign res_hs = prod_s[PW-1:W];
  assign res_hu = prod_u[PW-1:W];
  assign res_rn = round_hi(prod_s);

  mul_mode_e sel;
  assign sel = mul_mode_e'(mode);

  always_comb begin
    case (sel)
      MUL_LO:   y = res_lo;
      MUL_HI_S: y = res_hs;
      MUL_HI_U: y = res_hu;
      default:  y = res_rn;
    endcase
  end

  // cross-checks between independently formed products
  logic [W-1:0] corr_a, corr_b, rn_gap;
  assign corr_a = a[W-1] ? b : '0;
  assign corr_b = b[W-1] ? a : '0;
  assign rn_gap = res_rn - {res_hs[W-2:0], 1'b0};

  // R5
  hi_signed_unsigned_chk: assert property (@(posedge clk) disable iff (rst)
    res_hu == W'(res_hs + corr_a + corr_b));

  // R6
  round_near_hi_chk: assert property (@(posedge clk) disable iff (rst)
    rn_gap < W'(3));

  // R3
  low_half_agree_chk: assert property (@(posedge clk) disable iff (rst)
    res_lo == prod_s[W-1:0]);

endmodule

// File: rtl/pmh_pipe_reg.sv
module pmh_pipe_reg #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic          q_vld,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q     <= '0;
    end else begin
      q_vld <= en;
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/pmh_unit.sv
module pmh_unit #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_vld,
  input  logic [1:0]                mode,
  input  logic [LANES*LANE_W-1:0]   op_a,
  input  logic [LANES*LANE_W-1:0]   op_b,
  output logic                      out_vld,
  output logic [LANES*LANE_W-1:0]   out_data
);
  localparam int DW = LANES * LANE_W;

  logic [DW-1:0] lane_y;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pmh_lane #(.W(LANE_W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .a    (op_a[i*LANE_W +: LANE_W]),
      .b    (op_b[i*LANE_W +: LANE_W]),
      .y    (lane_y[i*LANE_W +: LANE_W])
    );
  end

  pmh_pipe_reg #(.DW(DW)) u_oreg (
    .clk   (clk),
    .rst   (rst),
    .en    (in_vld),
    .d     (lane_y),
    .q_vld (out_vld),
    .q     (out_data)
  );

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_vld && out_data == '0));

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_data));

endmodule

// File: tb/pmh_unit_tb.sv
module pmh_unit_tb;
  localparam int NL = 8;
  localparam int BW = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              vld_b = 1'b0, vld_s = 1'b0;
  logic [1:0]        mode_b = '0, mode_s = '0;
  logic [NL*BW-1:0]  a_b = '0, b_b = '0, y_b;
  logic [NL*SW-1:0]  a_s = '0, b_s = '0, y_s;
  logic              ov_b, ov_s;

  pmh_unit #(.LANES(NL), .LANE_W(BW)) u_dut (
    .clk(clk), .rst(rst), .in_vld(vld_b), .mode(mode_b),
    .op_a(a_b), .op_b(b_b), .out_vld(ov_b), .out_data(y_b));

  pmh_unit #(.LANES(NL), .LANE_W(SW)) u_dut_small (
    .clk(clk), .rst(rst), .in_vld(vld_s), .mode(mode_s),
    .op_a(a_s), .op_b(b_s), .out_vld(ov_s), .out_data(y_s));

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // integer reference model
  function automatic logic [15:0] ref_lane(input int w, input longint ua, input longint ub, input int md);
    longint sa, sb, p, m, r;
    m  = (longint'(1) << w) - 1;
    sa = (ua >= (longint'(1) << (w-1))) ? ua - (longint'(1) << w) : ua;
    sb = (ub >= (longint'(1) << (w-1))) ? ub - (longint'(1) << w) : ub;
    p  = sa * sb;
    case (md)
      0: r = p & m;
      1: r = (p >>> w) & m;
      2: r = ((ua * ub) >> w) & m;
      default: r = (((p >>> (w-2)) + 1) >>> 1) & m;
    endcase
    return 16'(r);
  endfunction

  function automatic string mode_req(input int md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic run_big(input int md, input logic [NL*BW-1:0] a, input logic [NL*BW-1:0] b, input string req);
    logic [NL*BW-1:0] exp;
    for (int i = 0; i < NL; i++)
      exp[i*BW +: BW] = ref_lane(BW, a[i*BW +: BW], b[i*BW +: BW], md);
    mode_b = 2'(md); a_b = a; b_b = b; vld_b = 1'b1;
    @(negedge clk);
    vld_b = 1'b0;
    check(req, 128'(y_b), 128'(exp));
    check("R2", 128'(ov_b), 128'(1));
  endtask

  task automatic run_small(input int md, input logic [NL*SW-1:0] a, input logic [NL*SW-1:0] b);
    logic [NL*SW-1:0] exp;
    for (int i = 0; i < NL; i++)
      exp[i*SW +: SW] = SW'(ref_lane(SW, a[i*SW +: SW], b[i*SW +: SW], md));
    mode_s = 2'(md); a_s = a; b_s = b; vld_s = 1'b1;
    @(negedge clk);
    vld_s = 1'b0;
    check(mode_req(md), 128'(y_s), 128'(exp));
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    logic [NL*BW-1:0] va, vb, held;
    logic [15:0] corners [8];
    corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h4000, 16'hC000, 16'h1234};

    repeat (2) @(negedge clk);
    // R1 during reset
    check("R1", 128'(ov_b), 128'(0));
    check("R1", 128'(y_b), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R1", 128'(ov_s), 128'(0));
    check("R1", 128'(y_s), 128'(0));

    // exhaustive 4-bit sweep, all modes (R3 R4 R5 R6 R8)
    for (int md = 0; md < 4; md++)
      for (int a = 0; a < 16; a++)
        for (int h = 0; h < 2; h++) begin
          logic [NL*SW-1:0] pa, pb;
          for (int i = 0; i < NL; i++) begin
            pa[i*SW +: SW] = SW'(a);
            pb[i*SW +: SW] = SW'(i + 8*h);
          end
          run_small(md, pa, pb);
        end

    // 16-bit corners: each lane pairs corner i with corner j
    for (int md = 0; md < 4; md++)
      for (int j = 0; j < 8; j++) begin
        for (int i = 0; i < NL; i++) begin
          va[i*BW +: BW] = corners[i];
          vb[i*BW +: BW] = corners[(i + j) % 8];
        end
        run_big(md, va, vb, mode_req(md));
      end

    // R7 most negative squared in rounding mode
    va = {NL{16'h8000}};
    run_big(3, va, va, "R7");
    check("R7", 128'(y_b[15:0]), 128'(16'h8000));

    // R8 single active lane
    va = '0; vb = '0;
    va[3*BW +: BW] = 16'h7FFF; vb[3*BW +: BW] = 16'h8001;
    for (int md = 0; md < 4; md++) run_big(md, va, vb, "R8");

    // pseudo-random vectors
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < NL; i++) begin
        lfsr = step(lfsr);
        va[i*BW +: BW] = lfsr[15:0];
        vb[i*BW +: BW] = lfsr[31:16];
      end
      run_big(n % 4, va, vb, mode_req(n % 4));
    end

    // R9 and R2: change operands and mode while idle
    held = y_b;
    a_b = ~a_b; b_b = b_b ^ {NL{16'h5A5A}}; mode_b = mode_b + 2'd1;
    @(negedge clk);
    check("R2", 128'(ov_b), 128'(0));
    check("R9", 128'(y_b), 128'(held));
    @(negedge clk);
    check("R9", 128'(y_b), 128'(held));

    // R1 reset again clears a loaded register
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", 128'(y_b), 128'(0));
    check("R1", 128'(ov_b), 128'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule